// File: doc/BRIEF.md
# Width-configurable asynchronous SRAM lane controller

This block sits between a synchronous host port and an asynchronous static RAM built from four byte-wide lanes. The lanes share one memory address, and each lane has its own active-low select and write strobe. The host places one read or write at a time on a valid/ready handshake. Each request carries a word address and a width mode of 32, 16 or 8 bits. The controller turns every request into a fixed sequence of clock cycles on the memory pins.

The width mode selects which lanes take part: all four, one pair, or a single lane. The low bits of the host address pick the pair or the lane, and the remaining bits form the memory address. Write data from the low end of the host word is copied onto every selected lane. Read data from the selected lanes is packed into the low end of the response, and the upper bits are cleared. The cycle lengths for the write pulse, the read access and the read-to-write gap are parameters. They are chosen so that the fixed clock meets the RAM's timing minimums.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While rst_n is low, every mem_cs_n and mem_we_n bit and mem_oe_n are high, and mem_dq_oe, rsp_valid and req_ready are low.
- R2: req_mode encodes the width. 2'b00 (and 2'b11) uses all four lanes. 2'b01 uses one pair: req_addr[0]=0 selects lanes 0-1 and 1 selects lanes 2-3. 2'b10 uses the single lane numbered req_addr[1:0]. Lane i carries data bits 8i+7:8i, and only the selected lanes' mem_cs_n bits go low.
- R3: mem_addr equals req_addr[16:0] in 32-bit mode, req_addr[17:1] in 16-bit mode and req_addr[18:2] in 8-bit mode.
- R4: On a write, lane i of mem_dq_out carries host byte (i mod n), where n is the number of lanes in use (4, 2 or 1).
- R5: A write follows the accept edge with one setup cycle (selects low, strobes high), then WR_PULSE cycles with the selected mem_we_n bits low, then one hold cycle (selects low, strobes high). mem_dq_oe is high exactly during the strobe cycles and the hold cycle.
- R6: A read holds the selected selects and mem_oe_n low for 1 + RD_ACCESS + 1 cycles after the accept edge, keeps every mem_we_n bit high, and samples mem_dq_in at the clock edge that ends this window.
- R7: The read response places the selected lanes, lowest lane first, in the low 8n bits of rsp_rdata and clears all bits above them.
- R8: rsp_valid is high for exactly one cycle, the cycle right after the selects are released, for both reads and writes. rsp_rdata is valid in that cycle for reads.
- R9: req_ready is high only while the controller is idle. A request is taken only on a cycle with req_valid and req_ready both high. Requests presented while busy are ignored.
- R10: After a read's response cycle, req_ready stays low for TURN further cycles before the next request can be taken.
- R11: A mem_we_n bit never goes low without its mem_cs_n bit low. mem_dq_oe is never high while mem_oe_n is low or while no lane is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width mode (see R2) |
| req_addr | input | 19 | Host word address in the selected width |
| req_wdata | input | 32 | Host write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-justified read data |
| mem_addr | output | 17 | Shared memory address |
| mem_cs_n | output | 4 | Per-lane active-low select |
| mem_we_n | output | 4 | Per-lane active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_in | input | 32 | Data returned by the memory |

## Verification
The collision that matters is between a read's final response cycle and a write request that is already waiting. On that edge the controller must refuse the write and hold it off through the turnaround gap. The bench provokes this by asserting the write request while a read is still in progress and holding req_valid high. The reference model expects req_ready low through the response and gap cycles, and it expects the write's select to fall only afterwards. A second case pulses a foreign write while a write is busy. A later read of that address must return the untouched contents.

// File: rtl/sram_ctrl_pkg.sv
// Shared encodings for the SRAM lane controller.
// Assumes: width-mode values are fixed by the host protocol.
package sram_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_W32 = 2'b00,
        MODE_W16 = 2'b01,
        MODE_W8  = 2'b10,
        MODE_ALT = 2'b11
    } width_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/sram_lane_decode.sv
// Splits a host word address into a memory address and a lane group.
// Assumes: LANES is a power of two of at least 2; unused mode 2'b11 acts as full width.
module sram_lane_decode
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int LANES  = 4,
    localparam int LSEL_W  = $clog2(LANES),
    localparam int HOST_AW = ADDR_W + LSEL_W
) (
    input  logic [1:0]         mode,
    input  logic [HOST_AW-1:0] host_addr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   lane_mask,
    output logic [LSEL_W-1:0]  first_lane,
    output logic [LSEL_W:0]    lane_count
);
    int gbits;
    int cnt;
    int first;
    logic [HOST_AW-1:0] shifted;

    // Pick group bits and lane count per mode, then derive address and mask.
    always_comb begin
        case (width_mode_e'(mode))
            MODE_W16: begin gbits = LSEL_W - 1; cnt = LANES / 2; end
            MODE_W8:  begin gbits = LSEL_W;     cnt = 1;         end
            default:  begin gbits = 0;          cnt = LANES;     end
        endcase
        shifted  = host_addr >> gbits;
        mem_addr = shifted[ADDR_W-1:0];
        first    = (int'(host_addr[LSEL_W-1:0]) & ((1 << gbits) - 1)) * cnt;
        for (int i = 0; i < LANES; i++) begin
            lane_mask[i] = (i >= first) && (i < first + cnt);
        end
        first_lane = LSEL_W'(first);
        lane_count = (LSEL_W + 1)'(cnt);
    end
endmodule

// File: rtl/sram_lane_steer.sv
// Replicates host write data over the lanes and right-justifies read lanes.
// Assumes: lane_count is 1, LANES/2 or LANES and first_lane is a multiple of it.
module sram_lane_steer #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int LSEL_W = $clog2(LANES),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LSEL_W-1:0] first_lane,
    input  logic [LSEL_W:0]   lane_count,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    int cnt;
    int first;

    // Copy the low host bytes onto every lane; pack the active lanes into the low end.
    always_comb begin
        cnt   = (int'(lane_count) == 0) ? 1 : int'(lane_count);
        first = int'(first_lane);
        host_rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            bus_wdata[i*LANE_W +: LANE_W] = host_wdata[(i % cnt)*LANE_W +: LANE_W];
            if (i < cnt) begin
                host_rdata[i*LANE_W +: LANE_W] = bus_rdata[((first + i) % LANES)*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/sram_seq.sv
// Cycle sequencer: setup, strobe window, hold/sample, done, plus read-to-write gap.
// Assumes: WR_PULSE and RD_ACCESS are at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int WR_PULSE  = 2,
    parameter int RD_ACCESS = 3,
    parameter int TURN      = 1,
    localparam int MAXC  = (WR_PULSE > RD_ACCESS) ? ((WR_PULSE > TURN) ? WR_PULSE : TURN)
                                                  : ((RD_ACCESS > TURN) ? RD_ACCESS : TURN),
    localparam int CNT_W = $clog2(MAXC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    output seq_state_e state,
    output logic       op_write,
    output logic       ready
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gap;

    // Advance through the access phases and count the strobe and gap windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            gap      <= '0;
            op_write <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (gap != '0) begin
                        gap <= gap - 1'b1;
                    end else if (start) begin
                        op_write <= is_write;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= op_write ? CNT_W'(WR_PULSE - 1) : CNT_W'(RD_ACCESS - 1);
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt == '0) state <= ST_HOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_HOLD: state <= ST_DONE;
                default: begin
                    gap   <= op_write ? '0 : CNT_W'(TURN);
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Idle with no pending gap means a request may be taken.
    always_comb ready = rst_n && (state == ST_IDLE) && (gap == '0);
endmodule

// File: rtl/sram_lane_ctrl.sv
// Top: host request port to byte-lane asynchronous SRAM pins.
// Assumes: one request in flight; memory read data settles within RD_ACCESS+1 cycles.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int WR_PULSE  = 2,
    parameter int RD_ACCESS = 3,
    parameter int TURN      = 1,
    localparam int LSEL_W  = $clog2(LANES),
    localparam int HOST_AW = ADDR_W + LSEL_W,
    localparam int DATA_W  = LANES * LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_mode,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_cs_n,
    output logic [LANES-1:0]   mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);
    seq_state_e         state;
    logic               op_write;
    logic               start;
    logic               active;
    logic [1:0]         lat_mode;
    logic [HOST_AW-1:0] lat_addr;
    logic [DATA_W-1:0]  lat_wdata;
    logic [DATA_W-1:0]  rdata_q;
    logic [LANES-1:0]   lane_mask;
    logic [LSEL_W-1:0]  first_lane;
    logic [LSEL_W:0]    lane_count;
    logic [DATA_W-1:0]  host_rdata;

    assign start = req_valid && req_ready;

    sram_seq #(.WR_PULSE(WR_PULSE), .RD_ACCESS(RD_ACCESS), .TURN(TURN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(req_write),
        .state(state), .op_write(op_write), .ready(req_ready)
    );

    sram_lane_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
        .mode(lat_mode), .host_addr(lat_addr), .mem_addr(mem_addr),
        .lane_mask(lane_mask), .first_lane(first_lane), .lane_count(lane_count)
    );

    sram_lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
        .host_wdata(lat_wdata), .first_lane(first_lane), .lane_count(lane_count),
        .bus_rdata(mem_dq_in), .bus_wdata(mem_dq_out), .host_rdata(host_rdata)
    );

    // Latch the request on acceptance so it stays stable through the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_mode  <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (start) begin
            lat_mode  <= req_mode;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    // Capture read data at the edge that closes the sample cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rdata_q <= '0;
        else if (state == ST_HOLD && !op_write)       rdata_q <= host_rdata;
    end

    // Derive memory strobes and bus drive from the phase; all inactive in reset.
    always_comb begin
        active    = rst_n && (state == ST_SETUP || state == ST_STROBE || state == ST_HOLD);
        mem_cs_n  = active ? ~lane_mask : '1;
        mem_we_n  = (rst_n && op_write && state == ST_STROBE) ? ~lane_mask : '1;
        mem_oe_n  = !(active && !op_write);
        mem_dq_oe = rst_n && op_write && (state == ST_STROBE || state == ST_HOLD);
        rsp_valid = rst_n && (state == ST_DONE);
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/sram_lane_ctrl_checker.sv
// Protocol checker for the SRAM lane controller pins; bound to every instance.
// Assumes: sampled on the controller clock.
module sram_lane_ctrl_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [LANES-1:0] mem_cs_n,
    input logic [LANES-1:0] mem_we_n,
    input logic             mem_oe_n,
    input logic             mem_dq_oe
);
    // R1: quiet pins during reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> ((&mem_cs_n) && (&mem_we_n) && mem_oe_n && !mem_dq_oe && !rsp_valid && !req_ready));

    // R2: only whole lane groups are selected
    assert_lane_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~mem_cs_n) == 0) || ($countones(~mem_cs_n) == 1) ||
        ($countones(~mem_cs_n) == 2) || ($countones(~mem_cs_n) == LANES));

    // R5: bus drive begins together with the write strobe
    assert_drive_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (mem_we_n != '1));

    // R8: completion is a single pulse with the selects released
    assert_single_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_rsp_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (&mem_cs_n));

    // R9: an accepted request makes the controller busy
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: strobes only on selected lanes; no drive against memory output
    assert_we_within_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1) |-> (mem_we_n == mem_cs_n));
    assert_no_contention_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && (mem_cs_n != '1)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_checker #(.LANES(LANES)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
    localparam int WRP = 2;
    localparam int RDA = 3;
    localparam int GAP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic [3:0]  mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] bmem [4][256];

    // reference model state
    bit          m_busy = 0, m_wr = 0, m_acc = 0;
    int          m_k = 0, m_turn = 0;
    logic [3:0]  m_mask;
    logic [16:0] m_maddr;
    logic [31:0] m_wbus, m_rdata;

    always #4 clk = ~clk;

    sram_lane_ctrl #(.WR_PULSE(WRP), .RD_ACCESS(RDA), .TURN(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // behavioural RAM: selected lanes with output enable low return stored bytes
    always_comb begin
        for (int l = 0; l < 4; l++) begin
            mem_dq_in[l*8 +: 8] = (!mem_cs_n[l] && !mem_oe_n) ? bmem[l][mem_addr[7:0]] : 8'hEE;
        end
    end

    function automatic void lanes_of(input logic [1:0] md, input logic [18:0] a,
                                     output int cnt, output int first, output logic [16:0] ma);
        case (md)
            2'b01:   begin cnt = 2; first = a[0] ? 2 : 0; ma = a[17:1]; end
            2'b10:   begin cnt = 1; first = int'(a[1:0]);  ma = a[18:2]; end
            default: begin cnt = 4; first = 0;             ma = a[16:0]; end
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // model advance on each clock edge
    always @(posedge clk) begin
        int cnt, first;
        m_acc = 0;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_turn = 0;
        end else if (m_busy) begin
            if (m_k == (m_wr ? WRP : RDA) + 3) begin
                m_busy = 0;
                m_turn = m_wr ? 0 : GAP;
            end else m_k++;
        end else if (m_turn > 0) begin
            m_turn--;
        end else if (req_valid) begin
            m_acc = 1; m_busy = 1; m_k = 1; m_wr = req_write;
            lanes_of(req_mode, req_addr, cnt, first, m_maddr);
            m_rdata = '0;
            for (int l = 0; l < 4; l++) begin
                m_mask[l] = (l >= first) && (l < first + cnt);
                m_wbus[l*8 +: 8] = req_wdata[(l % cnt)*8 +: 8];
            end
            for (int j = 0; j < cnt; j++) m_rdata[j*8 +: 8] = bmem[first + j][m_maddr[7:0]];
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [3:0] e_cs, e_we;
        bit e_oe, e_doe, e_rsp, e_rdy;
        int p;
        e_cs = 4'hF; e_we = 4'hF; e_oe = 1; e_doe = 0; e_rsp = 0;
        e_rdy = rst_n && !m_busy && (m_turn == 0);
        if (rst_n && m_busy) begin
            p = m_wr ? WRP : RDA;
            if (m_k <= p + 2) e_cs = ~m_mask;
            if (m_wr) begin
                if (m_k >= 2 && m_k <= p + 1) e_we = ~m_mask;
                if (m_k >= 2 && m_k <= p + 2) e_doe = 1;
            end else if (m_k <= p + 2) e_oe = 0;
            if (m_k == p + 3) e_rsp = 1;
        end
        if (!rst_n) begin
            chk(mem_cs_n === 4'hF && mem_we_n === 4'hF && mem_oe_n === 1'b1 &&
                mem_dq_oe === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b0,
                "R1 reset pins", {mem_cs_n, mem_we_n, 3'b0, mem_oe_n, mem_dq_oe, rsp_valid, req_ready},
                {4'hF, 4'hF, 3'b0, 1'b1, 3'b000});
        end else begin
            chk(mem_cs_n === e_cs, "R2 lane selects", {28'b0, mem_cs_n}, {28'b0, e_cs});
            chk(mem_we_n === e_we, "R5 write strobes", {28'b0, mem_we_n}, {28'b0, e_we});
            chk(mem_dq_oe === e_doe, "R5 bus drive", {31'b0, mem_dq_oe}, {31'b0, e_doe});
            chk(mem_oe_n === e_oe, "R6 output enable", {31'b0, mem_oe_n}, {31'b0, e_oe});
            chk(rsp_valid === e_rsp, "R8 response pulse", {31'b0, rsp_valid}, {31'b0, e_rsp});
            if (m_turn > 0)
                chk(req_ready === e_rdy, "R10 turnaround ready", {31'b0, req_ready}, {31'b0, e_rdy});
            else
                chk(req_ready === e_rdy, "R9 ready", {31'b0, req_ready}, {31'b0, e_rdy});
            if (e_cs !== 4'hF) chk(mem_addr === m_maddr, "R3 memory address", {15'b0, mem_addr}, {15'b0, m_maddr});
            if (e_doe) chk(mem_dq_out === m_wbus, "R4 write lanes", mem_dq_out, m_wbus);
            if (e_rsp && !m_wr) chk(rsp_rdata === m_rdata, "R7 read data", rsp_rdata, m_rdata);
            chk(((~mem_we_n) & mem_cs_n) === 4'h0 && !(mem_dq_oe && !mem_oe_n), "R11 strobe safety",
                {28'b0, (~mem_we_n) & mem_cs_n}, 32'h0);
            for (int l = 0; l < 4; l++) begin
                if (!mem_we_n[l] && !mem_cs_n[l] && mem_dq_oe) bmem[l][mem_addr[7:0]] = mem_dq_out[l*8 +: 8];
            end
        end
    end

    task automatic issue(input bit wr, input logic [1:0] md, input logic [18:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_mode = md; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!m_acc);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        while (m_busy || m_turn > 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < 256; i++) bmem[l][i] = 8'(l * 64 + i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 R3 R4 R7: full width write then read
        issue(1, 2'b00, 19'h00005, 32'hA5A5_1234); wait_idle();
        issue(0, 2'b00, 19'h00005, 32'h0);         wait_idle();
        // 16-bit upper pair write, then reads of both pairs and full word
        issue(1, 2'b01, 19'h0000B, 32'hFFFF_BEEF); wait_idle();
        issue(0, 2'b01, 19'h0000B, 32'h0);         wait_idle();
        issue(0, 2'b01, 19'h0000A, 32'h0);         wait_idle();
        issue(0, 2'b00, 19'h00005, 32'h0);         wait_idle();
        // 8-bit lanes at the top of the address range and mode 2'b11
        issue(1, 2'b10, 19'h7FFFE, 32'h1234_565A); wait_idle();
        for (int l = 0; l < 4; l++) begin
            issue(0, 2'b10, 19'h7FFFC | 19'(l), 32'h0); wait_idle();
        end
        issue(0, 2'b11, 19'h1FFFF, 32'h0);         wait_idle();
        // R9: foreign write pulsed while busy must be ignored
        issue(1, 2'b00, 19'h00020, 32'h0BAD_F00D);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_mode = 2'b00; req_addr = 19'h00030; req_wdata = 32'hDEAD_DEAD;
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        issue(0, 2'b00, 19'h00030, 32'h0);         wait_idle();
        // R10: write waiting behind a read collides with its response cycle
        issue(0, 2'b00, 19'h00020, 32'h0);
        issue(1, 2'b10, 19'h00041, 32'h0000_0077); wait_idle();
        issue(0, 2'b10, 19'h00041, 32'h0);         wait_idle();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end
endmodule